// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small processor subsystem run while the CPU sleeps. The CPU sets a sleep-enable bit, places a 3-bit mode code on `mode_sel` and pulses `sleep_req`. The controller then drops the clock enables of the CPU core, the SRAM, the I/O peripherals (timers, SPI, serial), the interrupt logic, the ADC, the asynchronous timer and the main oscillator. Six modes are supported, each with its own pattern of stopped domains. The pattern is captured when sleep begins, so later changes on `mode_sel` have no effect until the next entry.

While asleep, the controller watches four interrupt request lines and accepts one only if the domain that raises it is still clocked. The external interrupt line is always accepted. A synchronous reset also wakes the block. A mode that kept the main oscillator running resumes the CPU clock on the next cycle. A mode that stopped the oscillator first restarts the oscillator alone and waits a parameterised settling count, which stands in for oscillator start-up. Only then does it restore every clock.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: With the block running, a `sleep_req` pulse sampled at a clock edge while `sleep_en` is 1 enters sleep. The new enable pattern and `status` = 1 are visible after that same edge.
- R2: A `sleep_req` sampled while `sleep_en` is 0 is ignored: all enables stay 1 and `status` stays 0. A request or a `mode_sel` change made while asleep leaves the captured pattern unchanged.
- R3: Mode code 0 (CPU halt) stops only the CPU clock. Enable vector {cpu,sram,io,irq,adc,async,osc} = 0111111.
- R4: Mode code 1 (quiet conversion) keeps only the ADC, the asynchronous timer and the oscillator running: 0000111.
- R5: Mode code 2 (deep) stops every domain, including the oscillator: 0000000. In this mode only the external interrupt line wakes the block.
- R6: Mode code 3 (deep with timer) is as in R5, except that the asynchronous timer keeps running: 0000010. An asynchronous-timer interrupt wakes the block.
- R7: Mode code 6 (oscillator hold) keeps only the oscillator running: 0000001. On wake, all enables return one cycle after the wake edge.
- R8: Mode code 7 (oscillator and timer hold) keeps the oscillator and the asynchronous timer running: 0000011.
- R9: The reserved codes 4 and 5 behave exactly as code 0.
- R10: While asleep, `irq_ext` always wakes the block. `irq_io` wakes it only if the I/O domain is running, `irq_adc` only if the ADC is running, and `irq_async` only if the asynchronous timer is running. Any other request is ignored.
- R11: Waking from a mode with the oscillator stopped goes to `status` = 2 after the wake edge: oscillator enabled, CPU still stopped, the rest of the pattern unchanged. All enables return exactly SETTLE_CYC edges after the wake edge.
- R12: `rst_n` sampled low at a clock edge puts the block in the running state with all enables 1 after that edge, from any state.
- R13: `status` encodes 0 = running, 1 = asleep, 2 = waiting for the oscillator to settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset (hardware wake) |
| mode_sel | input | 3 | Sleep mode code |
| sleep_en | input | 1 | Sleep permitted |
| sleep_req | input | 1 | One-cycle sleep request strobe from the CPU |
| irq_ext | input | 1 | External interrupt request |
| irq_io | input | 1 | Interrupt from the I/O peripherals |
| irq_adc | input | 1 | ADC conversion-complete interrupt |
| irq_async | input | 1 | Asynchronous timer interrupt |
| clk_en_cpu | output | 1 | CPU core clock enable |
| clk_en_sram | output | 1 | SRAM clock enable |
| clk_en_io | output | 1 | I/O peripheral clock enable |
| clk_en_irq | output | 1 | Interrupt logic clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| clk_en_osc | output | 1 | Main oscillator enable |
| status | output | 2 | Controller state (R13) |

## Verification
Sleep entry, fast wake and reset each take effect one edge after the stimulus, so the bench changes inputs on the falling edge and checks outputs on the next falling edge. A wake from an oscillator-stopped mode is checked three times: one edge after the request (settling), SETTLE_CYC-1 edges later (still settling) and one edge after that (all clocks running). This pins the settling window to the exact cycle. A rejected wake request is held for two edges before the still-gated pattern is checked.

// File: rtl/slpc_pkg.sv
// Shared types for the sleep clock gating controller.
// Assumes the enable vector order cpu..osc is used consistently by all users.
package slpc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DOZE   = 2'd1,
        ST_SETTLE = 2'd2
    } slpc_state_e;

    typedef enum logic [2:0] {
        MD_CPU_HALT   = 3'd0,
        MD_QUIET_CONV = 3'd1,
        MD_DEEP       = 3'd2,
        MD_DEEP_TIMER = 3'd3,
        MD_OSC_HOLD   = 3'd6,
        MD_OSC_TIMER  = 3'd7
    } slpc_mode_e;

    typedef struct packed {
        logic cpu;
        logic sram;
        logic io;
        logic irq;
        logic adc;
        logic async_t;
        logic osc;
    } dom_en_t;

    localparam dom_en_t DOM_ALL_ON = 7'b111_1111;

endpackage

// File: rtl/slpc_mode_map.sv
// Maps a raw mode code onto the set of domains that keep running in sleep.
// Assumes unknown codes should fall back to the lightest mode (CPU halt).
module slpc_mode_map
    import slpc_pkg::*;
(
    input  logic [2:0] mode_raw,
    output dom_en_t    sleep_pat
);

    // Combinational decode of the mode code into a gating pattern.
    always_comb begin
        sleep_pat = DOM_ALL_ON;
        case (mode_raw)
            MD_QUIET_CONV: sleep_pat = 7'b000_0111;
            MD_DEEP:       sleep_pat = 7'b000_0000;
            MD_DEEP_TIMER: sleep_pat = 7'b000_0010;
            MD_OSC_HOLD:   sleep_pat = 7'b000_0001;
            MD_OSC_TIMER:  sleep_pat = 7'b000_0011;
            default:       sleep_pat = 7'b011_1111;
        endcase
    end

endmodule

// File: rtl/slpc_wake_gate.sv
// Qualifies interrupt requests against the domains still clocked in sleep.
// Assumes irq_ext comes from logic that needs no clock to flag a request.
module slpc_wake_gate (
    input  logic io_on,
    input  logic adc_on,
    input  logic async_on,
    input  logic irq_ext,
    input  logic irq_io,
    input  logic irq_adc,
    input  logic irq_async,
    output logic wake
);

    // A request counts only when its source domain can run.
    always_comb begin
        wake = irq_ext
             | (irq_io    & io_on)
             | (irq_adc   & adc_on)
             | (irq_async & async_on);
    end

endmodule

// File: rtl/slpc_settle_timer.sv
// Down-counter modelling oscillator settling after a deep wake.
// Assumes SETTLE_CYC >= 1; done is meaningful only while tick is held.
module slpc_settle_timer #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic done
);

    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LOAD_V = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    // Load on wake, then count down while settling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_V;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sleep_clkgate_ctrl.sv
// Sleep mode clock gating controller: captures a mode on a sleep request,
// gates domain clocks, accepts permitted wake requests and restores clocks,
// optionally after an oscillator settling delay.
// Assumes sleep_req is a single-cycle strobe synchronous to clk.
module sleep_clkgate_ctrl
    import slpc_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       sleep_en,
    input  logic       sleep_req,
    input  logic       irq_ext,
    input  logic       irq_io,
    input  logic       irq_adc,
    input  logic       irq_async,
    output logic       clk_en_cpu,
    output logic       clk_en_sram,
    output logic       clk_en_io,
    output logic       clk_en_irq,
    output logic       clk_en_adc,
    output logic       clk_en_async,
    output logic       clk_en_osc,
    output logic [1:0] status
);

    slpc_state_e state;
    dom_en_t     held_pat;
    dom_en_t     new_pat;
    dom_en_t     cur_en;
    logic        wake_ok;
    logic        settle_done;
    logic        settle_load;

    slpc_mode_map u_map (
        .mode_raw  (mode_sel),
        .sleep_pat (new_pat)
    );

    slpc_wake_gate u_wake (
        .io_on     (held_pat.io),
        .adc_on    (held_pat.adc),
        .async_on  (held_pat.async_t),
        .irq_ext   (irq_ext),
        .irq_io    (irq_io),
        .irq_adc   (irq_adc),
        .irq_async (irq_async),
        .wake      (wake_ok)
    );

    assign settle_load = (state == ST_DOZE) && wake_ok && !held_pat.osc;

    slpc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (settle_load),
        .tick  (state == ST_SETTLE),
        .done  (settle_done)
    );

    // State sequencing and capture of the gating pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            held_pat <= DOM_ALL_ON;
        end else begin
            case (state)
                ST_RUN: begin
                    if (sleep_req && sleep_en) begin
                        held_pat <= new_pat;
                        state    <= ST_DOZE;
                    end
                end
                ST_DOZE: begin
                    if (wake_ok) begin
                        state <= held_pat.osc ? ST_RUN : ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_done) begin
                        state <= ST_RUN;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // Enables as a function of state and the captured pattern.
    always_comb begin
        case (state)
            ST_DOZE:   cur_en = held_pat;
            ST_SETTLE: begin
                cur_en     = held_pat;
                cur_en.osc = 1'b1;
            end
            default:   cur_en = DOM_ALL_ON;
        endcase
    end

    assign clk_en_cpu   = cur_en.cpu;
    assign clk_en_sram  = cur_en.sram;
    assign clk_en_io    = cur_en.io;
    assign clk_en_irq   = cur_en.irq;
    assign clk_en_adc   = cur_en.adc;
    assign clk_en_async = cur_en.async_t;
    assign clk_en_osc   = cur_en.osc;
    assign status       = state;

    AST_ENTER_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && sleep_en) |=> !clk_en_cpu && status == 2'd1); // R1
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && !sleep_en) |=> clk_en_cpu && status == 2'd0); // R2
    AST_PATTERN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOZE && !wake_ok) |=> $stable(cur_en)); // R10
    AST_FAST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOZE && wake_ok && held_pat.osc) |=> clk_en_cpu && clk_en_sram); // R7
    AST_SLOW_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOZE && wake_ok && !held_pat.osc) |=> !clk_en_cpu && clk_en_osc); // R11
    AST_SETTLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && settle_done) |=> clk_en_cpu && status == 2'd0); // R11

endmodule

// File: tb/sleep_clkgate_ctrl_bench.sv
module sleep_clkgate_ctrl_bench;

    localparam int SETTLE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic       sleep_en = 1'b0;
    logic       sleep_req = 1'b0;
    logic       irq_ext = 1'b0;
    logic       irq_io = 1'b0;
    logic       irq_adc = 1'b0;
    logic       irq_async = 1'b0;
    logic       clk_en_cpu, clk_en_sram, clk_en_io, clk_en_irq;
    logic       clk_en_adc, clk_en_async, clk_en_osc;
    logic [1:0] status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sleep_clkgate_ctrl #(.SETTLE_CYC(SETTLE)) u_sleep_clkgate_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en),
        .sleep_req(sleep_req), .irq_ext(irq_ext), .irq_io(irq_io),
        .irq_adc(irq_adc), .irq_async(irq_async),
        .clk_en_cpu(clk_en_cpu), .clk_en_sram(clk_en_sram), .clk_en_io(clk_en_io),
        .clk_en_irq(clk_en_irq), .clk_en_adc(clk_en_adc),
        .clk_en_async(clk_en_async), .clk_en_osc(clk_en_osc), .status(status)
    );

    // Expected sleep pattern {cpu,sram,io,irq,adc,async,osc} per requirements.
    function automatic logic [7:0] exp_pat(input logic [2:0] m);
        case (m)
            3'd1:    return 8'h07;
            3'd2:    return 8'h00;
            3'd3:    return 8'h02;
            3'd6:    return 8'h01;
            3'd7:    return 8'h03;
            default: return 8'h3F;
        endcase
    endfunction

    function automatic logic [7:0] got_pat();
        return {1'b0, clk_en_cpu, clk_en_sram, clk_en_io, clk_en_irq,
                clk_en_adc, clk_en_async, clk_en_osc};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter(input logic [2:0] m);
        mode_sel  = m;
        sleep_en  = 1'b1;
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        check("R12 reset enables", got_pat(), 8'h7F);
        check("R13 reset status", {6'd0, status}, 8'd0);
    endtask

    task automatic t_ignore_disabled();
        mode_sel  = 3'd2;
        sleep_en  = 1'b0;
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        check("R2 req without enable", got_pat(), 8'h7F);
        check("R2 status stays running", {6'd0, status}, 8'd0);
    endtask

    // Enter a mode, check the pattern, wake by irq_ext, check the timing.
    task automatic t_mode_cycle(input logic [2:0] m, input string tag);
        logic [7:0] p;
        p = exp_pat(m);
        enter(m);
        check({tag, " sleep pattern"}, got_pat(), p);
        check("R1 status asleep", {6'd0, status}, 8'd1);
        irq_ext = 1'b1;
        step(1);
        irq_ext = 1'b0;
        if (p[0]) begin
            check("R7 fast wake enables", got_pat(), 8'h7F);
        end else begin
            check("R11 settle pattern", got_pat(), p | 8'h01);
            check("R13 settle status", {6'd0, status}, 8'd2);
            step(SETTLE - 1);
            check("R11 still settling", {6'd0, status}, 8'd2);
            step(1);
            check("R11 clocks restored", got_pat(), 8'h7F);
        end
    endtask

    // Raise one interrupt line while asleep in mode m; expect wake or not.
    task automatic t_wake_src(input logic [2:0] m, input int src, input bit should_wake, input string tag);
        enter(m);
        case (src)
            1: irq_io = 1'b1;
            2: irq_adc = 1'b1;
            default: irq_async = 1'b1;
        endcase
        step(2);
        irq_io = 1'b0; irq_adc = 1'b0; irq_async = 1'b0;
        if (should_wake) begin
            if (exp_pat(m)[0] == 1'b0) step(SETTLE);
            check({tag, " woke"}, {6'd0, status}, 8'd0);
        end else begin
            check({tag, " ignored status"}, {6'd0, status}, 8'd1);
            check({tag, " ignored pattern"}, got_pat(), exp_pat(m));
            irq_ext = 1'b1;
            step(1);
            irq_ext = 1'b0;
            step(SETTLE + 1);
        end
    endtask

    task automatic t_latched_mode();
        enter(3'd6);
        mode_sel  = 3'd0;
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        check("R2 asleep request keeps pattern", got_pat(), 8'h01);
        irq_ext = 1'b1;
        step(1);
        irq_ext = 1'b0;
    endtask

    task automatic t_reset_in_settle();
        enter(3'd2);
        irq_ext = 1'b1;
        step(1);
        irq_ext = 1'b0;
        step(2);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        check("R12 reset during settle", got_pat(), 8'h7F);
        check("R12 reset status", {6'd0, status}, 8'd0);
    endtask

    initial begin
        step(1);
        t_reset();
        t_ignore_disabled();
        t_mode_cycle(3'd0, "R3");
        t_mode_cycle(3'd1, "R4");
        t_mode_cycle(3'd2, "R5");
        t_mode_cycle(3'd3, "R6");
        t_mode_cycle(3'd6, "R7");
        t_mode_cycle(3'd7, "R8");
        t_mode_cycle(3'd4, "R9");
        t_mode_cycle(3'd5, "R9");
        t_wake_src(3'd0, 1, 1'b1, "R10 io irq in halt");
        t_wake_src(3'd2, 1, 1'b0, "R5 io irq in deep");
        t_wake_src(3'd2, 2, 1'b0, "R5 adc irq in deep");
        t_wake_src(3'd2, 3, 1'b0, "R5 async irq in deep");
        t_wake_src(3'd1, 1, 1'b0, "R10 io irq in quiet conv");
        t_wake_src(3'd1, 2, 1'b1, "R10 adc irq in quiet conv");
        t_wake_src(3'd3, 3, 1'b1, "R6 async irq in deep timer");
        t_wake_src(3'd6, 3, 1'b0, "R10 async irq in osc hold");
        t_wake_src(3'd7, 3, 1'b1, "R8 async irq in osc timer");
        t_latched_mode();
        t_reset_in_settle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule